// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block is the synchronous front end of a flow-through burst static RAM, with a small lane-sliced storage array behind it. On every rising clock edge it captures the address, the three chip enables, two address strobes, the burst-advance input and the write controls. It classifies each edge as one of four cycle kinds: deselect, begin burst, step burst (next address) or hold burst (same address). Each begin, step or hold cycle is a read or a write. Write cycles store the data bus into the byte lanes picked by the write controls, at the address the cycle selects.

There are two address strobes. The processor strobe is honoured only while the primary enable is active, and it always opens a read. The controller strobe opens a read or a write, depending on the write controls. The two secondary enables are looked at only on edges where a strobe takes effect. Read data is flow-through: it follows the address captured at the most recent edge, within that same cycle. An output-enable flag reports when the data bus would be driven. The output-enable input gates that flag combinationally, without waiting for a clock edge.

Top module: `burst_sram_front`

## Requirements
- R1: A synchronous active-high reset leaves the block deselected: `dout_en` is 0 after the reset edge and no write takes place on it.
- R2: An edge with `pstrb_n`=0, `ce_n`=0, `ce2`=1 and `ce2_n`=0 begins a read at `addr`, whatever the write controls show. After that edge `dout` equals the stored word at `addr`.
- R3: While `ce_n`=1 the processor strobe is ignored. The edge then behaves as if no strobe were present (step, hold or stay deselected).
- R4: An edge with `cstrb_n`=0, no effective processor strobe and all three enables active begins a burst at `addr`. The burst is a write when the write decode is active and a read otherwise.
- R5: On an edge where a strobe takes effect, `ce2`=0, `ce2_n`=1 or (for the controller strobe) `ce_n`=1 gives a deselect cycle: `dout_en` is 0 and nothing is written.
- R6: With no effective strobe during a burst, `adv_n`=0 steps to the next address. Address bits [1:0] count up modulo 4 and the upper bits stay the same.
- R7: With no effective strobe during a burst, `adv_n`=1 holds the current address (wait state).
- R8: The write decode is active when `gw_n`=0, or when `bwe_n`=0 and some `bw_n` bit is 0. With `gw_n`=0 every lane is written. Otherwise lane i (data bits [9i+8:9i]) is written only when `bw_n[i]`=0. All other lanes keep their old contents.
- R9: A write after a processor-strobe begin is made on the following edge: a hold cycle with the write controls active writes `din` to the address captured by the strobe.
- R10: `dout_en` is 1 only in a read cycle and only while `oe_n`=0. `oe_n` acts without a clock edge.
- R11: Edges without an effective strobe leave a deselected block deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address captured when a burst begins |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Enables the per-lane write bits, active low |
| bw_n | input | LANES | Per-lane write bits, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Data bus would be driven |

## Verification
The hardest situation to reach is a processor-strobe begin with the write controls already active, followed by a hold cycle that writes only some lanes. In the same stretch, a primary-enable-high edge must stay masked while the controller strobe is idle. Random stimulus seldom produces these sequences in the order needed. A directed stretch therefore builds them: a strobe read with active write controls, a partial-lane hold write, a masked strobe that continues the burst, and a read-back. It runs before a long random phase, in which biased strobe and enable probabilities keep bursts open for several edges.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   // cycle kind decided at each rising edge
   typedef enum logic [1:0] {
      CYC_OFF   = 2'd0,
      CYC_START = 2'd1,
      CYC_STEP  = 2'd2,
      CYC_HOLD  = 2'd3
   } cyc_e;
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
   import burst_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             pstrb_n,
   input  logic             cstrb_n,
   input  logic             adv_n,
   input  logic             ce_n,
   input  logic             ce2,
   input  logic             ce2_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   input  logic             live,
   output cyc_e             kind,
   output logic [LANES-1:0] lane_we
);
   logic proc_hit;
   logic ctrl_hit;
   logic side_ok;
   logic [LANES-1:0] mask;
   logic wdec;

   // processor strobe is masked by the primary enable
   assign proc_hit = !pstrb_n && !ce_n;
   assign ctrl_hit = !cstrb_n && !proc_hit;
   assign side_ok  = ce2 && !ce2_n;

   always_comb begin
      if (!gw_n)       mask = '1;
      else if (!bwe_n) mask = ~bw_n;
      else             mask = '0;
   end
   assign wdec = |mask;

   always_comb begin
      if (proc_hit)      kind = side_ok ? CYC_START : CYC_OFF;
      else if (ctrl_hit) kind = (side_ok && !ce_n) ? CYC_START : CYC_OFF;
      else if (live)     kind = adv_n ? CYC_HOLD : CYC_STEP;
      else               kind = CYC_OFF;
   end

   // a processor-strobe begin is always a read
   assign lane_we = (kind != CYC_OFF && !proc_hit && wdec) ? mask : '0;
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] nxt
);
   localparam int LOW_W = 2;
   logic [LOW_W-1:0] low_inc;

   // linear order, wrapping inside an aligned group of four words
   assign low_inc = base[LOW_W-1:0] + LOW_W'(1);
   assign nxt     = {base[ADDR_W-1:LOW_W], low_inc};
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  lane_we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      always_ff @(posedge clk) begin
         if (lane_we[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
   end
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
   import burst_sram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pstrb_n,
   input  logic              cstrb_n,
   input  logic              adv_n,
   input  logic              ce_n,
   input  logic              ce2,
   input  logic              ce2_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("burst_sram_front: LANES must be 1..8");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("burst_sram_front: LANE_W must be positive");
   end
   if (DEPTH < 8 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("burst_sram_front: DEPTH must be a power of two of at least 8");
   end

   cyc_e              kind;
   logic [LANES-1:0]  lane_we_raw;
   logic [LANES-1:0]  lane_we;
   logic              live_q;
   logic              rd_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] step_addr;
   logic [ADDR_W-1:0] eff_addr;

   burst_sram_decode #(.LANES(LANES)) u_dec (
      .pstrb_n (pstrb_n),
      .cstrb_n (cstrb_n),
      .adv_n   (adv_n),
      .ce_n    (ce_n),
      .ce2     (ce2),
      .ce2_n   (ce2_n),
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bw_n    (bw_n),
      .live    (live_q),
      .kind    (kind),
      .lane_we (lane_we_raw)
   );

   burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
      .base (cur_q),
      .nxt  (step_addr)
   );

   always_comb begin
      case (kind)
         CYC_START: eff_addr = addr;
         CYC_STEP:  eff_addr = step_addr;
         default:   eff_addr = cur_q;
      endcase
   end

   assign lane_we = rst ? '0 : lane_we_raw;

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q <= 1'b0;
         rd_q   <= 1'b0;
         cur_q  <= '0;
      end else begin
         live_q <= (kind != CYC_OFF);
         rd_q   <= (kind != CYC_OFF) && !(|lane_we_raw);
         cur_q  <= eff_addr;
      end
   end

   burst_sram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
      .clk     (clk),
      .lane_we (lane_we),
      .waddr   (eff_addr),
      .wdata   (din),
      .raddr   (cur_q),
      .rdata   (dout)
   );

   assign dout_en = rd_q && !oe_n;
endmodule

// File: rtl/burst_sram_front_chk.sv
module burst_sram_front_chk #(
   parameter int LANES  = 4,
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst,
   input logic              pstrb_n,
   input logic              cstrb_n,
   input logic              adv_n,
   input logic              ce_n,
   input logic              ce2,
   input logic              ce2_n,
   input logic              gw_n,
   input logic              bwe_n,
   input logic [LANES-1:0]  bw_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);
   logic wdec;
   logic proc_eff;
   logic any_strobe;
   assign wdec       = !gw_n || (!bwe_n && !(&bw_n));
   assign proc_eff   = !pstrb_n && !ce_n;
   assign any_strobe = proc_eff || !cstrb_n;

   // R10: bus flag never raised while output enable is inactive
   assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
      dout_en |-> !oe_n);

   // R2: processor-strobe begin is a read
   assert_proc_read_R2: assert property (@(posedge clk) disable iff (rst)
      (proc_eff && ce2 && !ce2_n) |=> (dout_en == !oe_n));

   // R5: inactive enable on a strobe edge gives deselect
   assert_strobe_deselect_R5: assert property (@(posedge clk) disable iff (rst)
      (any_strobe && (ce_n || !ce2 || ce2_n)) |=> !dout_en);

   // R4: controller-strobe begin with write decode is a write cycle
   assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (rst)
      (!proc_eff && !cstrb_n && !ce_n && ce2 && !ce2_n && wdec) |=> !dout_en);

   // R7: a held read keeps the same data
   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
      (dout_en && !any_strobe && adv_n && !wdec) |=> $stable(dout));
endmodule

bind burst_sram_front burst_sram_front_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .pstrb_n (pstrb_n),
   .cstrb_n (cstrb_n),
   .adv_n   (adv_n),
   .ce_n    (ce_n),
   .ce2     (ce2),
   .ce2_n   (ce2_n),
   .gw_n    (gw_n),
   .bwe_n   (bwe_n),
   .bw_n    (bw_n),
   .oe_n    (oe_n),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/burst_sram_front_bench.sv
module burst_sram_front_bench;
   localparam int PERIOD = 10;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int DEPTH  = 256;
   localparam int AW     = 8;
   localparam int DW     = LANES * LANE_W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
   logic          ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
   logic          gw_n = 1'b1, bwe_n = 1'b1;
   logic [LANES-1:0] bw_n = '1;
   logic          oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #(PERIOD/2) clk = ~clk;

   burst_sram_front #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_burst_sram_front (
      .clk(clk), .rst(rst), .addr(addr), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
      .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din), .dout(dout),
      .dout_en(dout_en));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state
   logic [DW-1:0] m_mem [DEPTH];
   logic          m_live = 1'b0;
   logic          m_rd   = 1'b0;
   logic [AW-1:0] m_addr = '0;
   string         m_tag  = "R1";

   task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [LANES-1:0] lanes_hit(input logic g, input logic be, input logic [LANES-1:0] b);
      if (g == 1'b0) return '1;
      if (be == 1'b0) return ~b;
      return '0;
   endfunction

   // spec model applied at each rising edge with the driven inputs
   task automatic model_edge();
      logic [LANES-1:0] m;
      logic proc, ctrl, go, wr;
      logic [AW-1:0] ea;
      if (rst) begin
         m_live = 1'b0; m_rd = 1'b0; m_addr = '0; m_tag = "R1";
         return;
      end
      m    = lanes_hit(gw_n, bwe_n, bw_n);
      proc = (pstrb_n == 1'b0) && (ce_n == 1'b0);
      ctrl = (cstrb_n == 1'b0) && !proc;
      go   = 1'b0; wr = 1'b0; ea = m_addr;
      if (proc) begin
         go = ce2 && !ce2_n; ea = addr; m_tag = go ? "R2" : "R5";
      end else if (ctrl) begin
         go = !ce_n && ce2 && !ce2_n; ea = addr; wr = go && (m != 0);
         m_tag = go ? "R4" : "R5";
      end else if (m_live) begin
         go = 1'b1; wr = (m != 0);
         if (!adv_n) begin
            ea = {m_addr[AW-1:2], m_addr[1:0] + 2'd1}; m_tag = "R6";
         end else m_tag = "R7";
         if (!pstrb_n) m_tag = "R3";
      end else begin
         m_tag = pstrb_n ? "R11" : "R3";
      end
      if (wr) begin
         for (int i = 0; i < LANES; i++)
            if (m[i]) m_mem[ea][i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
         if (m != '1 && m_tag != "R5") m_tag = "R8";
      end
      m_live = go; m_rd = go && !wr; m_addr = ea;
   endtask

   task automatic check_out(input string tag);
      logic exp_en;
      exp_en = m_rd && !oe_n;
      cmp(tag, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, exp_en});
      if (exp_en) cmp(tag, dout, m_mem[m_addr]);
   endtask

   // drive at falling edge, model at rising edge, sample at next falling edge
   task automatic cyc(input logic [AW-1:0] a, input logic p, input logic c, input logic v,
                      input logic e1, input logic e2, input logic e2n,
                      input logic g, input logic be, input logic [LANES-1:0] b,
                      input logic oe, input logic [DW-1:0] d);
      addr = a; pstrb_n = p; cstrb_n = c; adv_n = v; ce_n = e1; ce2 = e2; ce2_n = e2n;
      gw_n = g; bwe_n = be; bw_n = b; oe_n = oe; din = d;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_out(m_tag);
   endtask

   function automatic logic [DW-1:0] rnd_data();
      return DW'({$urandom, $urandom});
   endfunction

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      @(negedge clk);
      rst = 1'b1;
      cyc(8'h00, 1, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      cyc(8'h00, 1, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      check_out("R1");
      rst = 1'b0;

      // fill: controller-strobe write bursts, full lanes, stepping (R4, R6)
      for (int k = 0; k < DEPTH/4; k++) begin
         cyc(AW'(k*4), 1, 0, 1, 0, 1, 0, 0, 1, '1, 1, rnd_data());
         for (int s = 0; s < 3; s++)
            cyc(8'h00, 1, 1, 0, 0, 1, 0, 0, 1, '1, 1, rnd_data());
      end

      // R6: read burst wrapping from low bits 2
      cyc(8'h22, 0, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      for (int s = 0; s < 4; s++) cyc(8'h00, 1, 1, 0, 0, 1, 0, 1, 1, '1, 0, '0);
      // R7: wait states
      cyc(8'h00, 1, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      cyc(8'h00, 1, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);

      // R2 then R9: strobe read with write controls active, hold-cycle partial write
      cyc(8'h51, 0, 1, 1, 0, 1, 0, 0, 0, 4'b0000, 0, 36'hFFFFFFFFF);
      cyc(8'h00, 1, 1, 1, 0, 1, 0, 1, 0, 4'b1010, 0, 36'h123456789);
      check_out("R9");
      // R3: masked processor strobe continues the burst (step)
      cyc(8'h99, 0, 1, 0, 1, 1, 0, 1, 1, '1, 0, '0);
      check_out("R3");
      // read-back of the partial write (R8, R9)
      cyc(8'h51, 0, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      check_out("R9");

      // R10: output enable toggles without an edge
      oe_n = 1'b1; #1; check_out("R10");
      oe_n = 1'b0; #1; check_out("R10");
      @(negedge clk);
      m_tag = "R10";

      // R5: controller strobe with secondary enable inactive, then idle (R11)
      cyc(8'h10, 1, 0, 1, 0, 0, 0, 0, 1, '1, 0, 36'hABCDE);
      check_out("R5");
      cyc(8'h00, 1, 1, 0, 0, 1, 0, 0, 1, '1, 0, '0);
      check_out("R11");
      cyc(8'h10, 1, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      check_out("R11");
      // R3 from deselect: masked strobe does not begin
      cyc(8'h10, 0, 1, 1, 1, 1, 0, 1, 1, '1, 0, '0);
      check_out("R3");
      // R5: controller strobe with primary enable inactive
      cyc(8'h10, 1, 0, 1, 1, 1, 0, 1, 1, '1, 0, '0);
      check_out("R5");

      // R1: reset mid-burst
      cyc(8'h33, 0, 1, 1, 0, 1, 0, 1, 1, '1, 0, '0);
      rst = 1'b1;
      cyc(8'h00, 1, 0, 1, 0, 1, 0, 0, 1, '1, 0, 36'h0);
      check_out("R1");
      rst = 1'b0;

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] r;
         r = 4'($urandom);
         cyc(AW'($urandom),
             ($urandom % 5) != 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
             ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
             ($urandom % 6) != 0, ($urandom % 2) == 0, r,
             ($urandom % 6) == 0, rnd_data());
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule